// File: doc/BRIEF.md
# Output Clock Divider with Phase Slip

This block derives an output data clock from a fast source clock. The divisor is either one (pass-through) or two. Alongside the clock it drives a data-valid strobe that marks the source cycle in which each output clock rising edge occurs. A downstream capture register can use this strobe as its enable.

A software-controlled phase slip moves the divided clock by exactly one source period. The control bit arrives as the level held in a register. A slip is requested only when that bit goes from 0 to 1, so software arms it by writing 0 and then 1. In divide-by-two mode, the slip holds the current output level for one extra source cycle. Every later edge therefore lands one source period away from where it would have been. Over a two-cycle period, that is the same as moving the rising edge one source period earlier. Slips accumulate.

The divisor input has already been resolved from a pin or a register. When it changes, the divider restarts from a known phase. Control pins are plain levels. There is no data stream and so no back-pressure.

Top module: `oclk_divider_slip`

## Requirements
- R1: With `div_sel`=1 (divide by one), `oclk` equals `clk` and `dvalid` is 1 in every cycle.
- R2: With `div_sel`=0 (divide by two) and no slip, `oclk` is a register that inverts at every rising edge of `clk`.
- R3: A slip request exists in a cycle only if `slip_ctl` is 1 in that cycle and was 0 in the previous cycle. Holding `slip_ctl` at 1 gives no further request. After reset, `slip_ctl` must be seen at 0 before a request can occur.
- R4: In divide-by-two mode, a slip request keeps `oclk` at its present level across the next `clk` edge. All later edges move by one source period, and successive slips accumulate.
- R5: In divide-by-two mode, no high or low level of `oclk` lasts less than one `clk` period.
- R6: In divide-by-one mode, a slip request has no effect on `oclk` or `dvalid`.
- R7: When `div_sel` differs from the registered mode at a `clk` edge, the new mode is taken and the divider restarts. In the following cycle `oclk` is low (in divide by two) and `dvalid` is 0.
- R8: In divide-by-two mode, `dvalid` is 1 exactly in the cycles where `oclk` rose at the preceding `clk` edge.
- R9: While `rst_n` is low, `oclk` is low, `dvalid` is 0 and the mode is divide by two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 1 | Resolved divisor: 0 = divide by two, 1 = divide by one |
| slip_ctl | input | 1 | Phase-slip control bit level; a 0-to-1 change requests a slip |
| oclk | output | 1 | Output data clock |
| dvalid | output | 1 | High in the source cycle holding an output clock rising edge |

## Verification
The bench targets several likely mistakes:
- A level-sensitive detector would slip on every cycle that `slip_ctl` stays at 1, and would hold `oclk` for many cycles.
- A detector that resets its history to 0 would slip on a 1 present just after reset.
- A slip made by toggling twice would create a half-width pulse and move `dvalid` away from the edge.
- A divider that keeps its phase over a divisor change would restart out of phase.

Back-to-back slips, slips in divide-by-one mode and slips that land on a divisor change are driven directly. Random toggling of both controls covers the cases in between.

// File: rtl/oclk_div_pkg.sv
package oclk_div_pkg;
  typedef enum logic {
    DIV_BY2 = 1'b0,
    DIV_BY1 = 1'b1
  } div_mode_e;
endpackage

// File: rtl/oclk_slip_edge.sv
module oclk_slip_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic slip_ctl,
  output logic slip_req
);
  // history starts at 1 so a bit already set at reset cannot slip
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= slip_ctl;
  end

  assign slip_req = slip_ctl & ~prev_q;

  // R3
  single_slip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slip_req |=> !slip_req);
endmodule

// File: rtl/oclk_phase_gen.sv
module oclk_phase_gen
  import oclk_div_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  div_mode_e mode_sel,
  input  logic      slip_req,
  output div_mode_e mode_q,
  output logic      ph_q,
  output logic      strobe_q
);
  logic restart;
  logic ph_d;
  logic strobe_d;

  assign restart = (mode_sel != mode_q);

  always_comb begin
    ph_d     = ph_q;
    strobe_d = 1'b0;
    if (restart) begin
      ph_d     = 1'b0;
      strobe_d = 1'b0;
    end else if (mode_q == DIV_BY1) begin
      ph_d     = 1'b0;
      strobe_d = 1'b1;
    end else if (slip_req) begin
      ph_d     = ph_q;
      strobe_d = 1'b0;
    end else begin
      ph_d     = ~ph_q;
      strobe_d = ~ph_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= DIV_BY2;
      ph_q     <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      mode_q   <= mode_sel;
      ph_q     <= ph_d;
      strobe_q <= strobe_d;
    end
  end

  // R2
  div2_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == DIV_BY2 && !restart && !slip_req) |=> (ph_q != $past(ph_q)));
  // R4
  slip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == DIV_BY2 && !restart && slip_req) |=> $stable(ph_q));
  // R7
  restart_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!ph_q && !strobe_q));
  // R8
  strobe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_q && mode_q == DIV_BY2) |-> (ph_q && !$past(ph_q)));
endmodule

// File: rtl/oclk_out_mux.sv
module oclk_out_mux
  import oclk_div_pkg::*;
(
  input  logic      clk,
  input  div_mode_e mode_q,
  input  logic      ph_q,
  input  logic      strobe_q,
  output logic      oclk,
  output logic      dvalid
);
  assign oclk   = (mode_q == DIV_BY1) ? clk : ph_q;
  assign dvalid = strobe_q;
endmodule

// File: rtl/oclk_divider_slip.sv
module oclk_divider_slip
  import oclk_div_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic div_sel,
  input  logic slip_ctl,
  output logic oclk,
  output logic dvalid
);
  logic      slip_req;
  div_mode_e mode_sel;
  div_mode_e mode_q;
  logic      ph_q;
  logic      strobe_q;

  assign mode_sel = div_mode_e'(div_sel);

  oclk_slip_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .slip_ctl (slip_ctl),
    .slip_req (slip_req)
  );

  oclk_phase_gen u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_sel (mode_sel),
    .slip_req (slip_req),
    .mode_q   (mode_q),
    .ph_q     (ph_q),
    .strobe_q (strobe_q)
  );

  oclk_out_mux u_mux (
    .clk      (clk),
    .mode_q   (mode_q),
    .ph_q     (ph_q),
    .strobe_q (strobe_q),
    .oclk     (oclk),
    .dvalid   (dvalid)
  );

  // R6
  div1_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == DIV_BY1 && mode_sel == DIV_BY1) |=> dvalid);
endmodule

// File: tb/oclk_divider_slip_tb.sv
`timescale 1ns/1ps
module oclk_divider_slip_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic div_sel = 1'b0;
  logic slip_ctl = 1'b0;
  logic oclk;
  logic dvalid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic m_div, m_prev, m_ph, m_dv;

  always #2.5 clk = ~clk;

  oclk_divider_slip dut_i (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel),
    .slip_ctl(slip_ctl), .oclk(oclk), .dvalid(dvalid)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model advanced once per rising edge of clk
  task automatic model_edge();
    logic req;
    req = slip_ctl & ~m_prev;
    m_prev = slip_ctl;
    if (div_sel != m_div) begin
      m_div = div_sel; m_ph = 1'b0; m_dv = 1'b0;
    end else if (m_div) begin
      m_ph = 1'b0; m_dv = 1'b1;
    end else if (req) begin
      m_dv = 1'b0;
    end else begin
      m_dv = ~m_ph; m_ph = ~m_ph;
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    #1;
    if (m_div) chk({tag, " R1 oclk high phase"}, oclk, 1'b1);
    @(negedge clk);
    if (!m_div) chk({tag, " oclk"}, oclk, m_ph);
    else        chk({tag, " R1 oclk low phase"}, oclk, 1'b0);
    chk({tag, " dvalid"}, dvalid, m_dv);
  endtask

  initial begin
    m_div = 0; m_prev = 1; m_ph = 0; m_dv = 0;
    repeat (3) @(negedge clk);
    chk("R9 reset oclk", oclk, 1'b0);
    chk("R9 reset dvalid", dvalid, 1'b0);
    // R3: bit already 1 when reset releases must not slip
    slip_ctl = 1'b1;
    rst_n = 1'b1;
    repeat (4) step("R3 set at reset");
    // R2 plain division
    repeat (6) step("R2 divide by two");
    // R4 single armed slip
    slip_ctl = 1'b0; step("R3 arm");
    slip_ctl = 1'b1; repeat (5) step("R4 one slip");
    // R3 rewrite of 1 gives nothing
    repeat (4) step("R3 held one");
    // R4 back-to-back slips accumulate; R5 no short level
    for (int k = 0; k < 3; k++) begin
      slip_ctl = 1'b0; step("R5 arm");
      slip_ctl = 1'b1; step("R4 accumulate");
    end
    repeat (3) step("R8 after slips");
    // R7 divisor change restarts
    div_sel = 1'b1; slip_ctl = 1'b0; step("R7 to div1");
    repeat (3) step("R1 divide by one");
    // R6 slip in divide by one
    slip_ctl = 1'b1; repeat (3) step("R6 slip in div1");
    slip_ctl = 1'b0; step("R6 arm div1");
    // slip landing on a divisor change
    slip_ctl = 1'b1; div_sel = 1'b0; step("R7 slip on change");
    repeat (4) step("R7 restart phase");
    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(99) < 30) slip_ctl = ~slip_ctl;
      if ($urandom_range(99) < 2)  div_sel  = ~div_sel;
      step("R4 R8 random");
    end
    done = 1;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule